// File: doc/BRIEF.md
# Work-RAM Overlay Bank Mapper

This block is the bank-switching logic of a game cartridge for an 8-bit console. Three write-only control registers are placed over the top three bytes of the 8 KB work-RAM window at $6000-$7FFF. One register picks the 32 KB program ROM bank seen by the CPU at $8000-$FFFF. The other two pick 4 KB character ROM banks, one for each half of the PPU pattern space. A CPU write to one of those three addresses loads the matching register, and the work RAM does not see that write. Every other write inside the window reaches the work RAM unchanged.

The block takes the CPU address, data and write strobe, and the PPU address. It returns the composed program ROM and character ROM addresses, a character ROM enable, and a gated work-RAM write enable. ROM sizes are parameters. Each bank number is masked down to the banks that exist when it is written. Register writes take effect on the clock edge that samples the strobe. The address outputs and the work-RAM enable are combinational.

Top module: `ovl_bank_mapper`

## Requirements
- R1: A write (cpu_wr high at a rising clock edge) to $7FFD loads the program bank. From the next cycle, prg_addr bits above bit 14 equal the masked bank.
- R2: A write to $7FFE loads the character bank for PPU addresses $0000-$0FFF (ppu_addr[12] = 0). It shows in chr_addr bits above bit 11 from the next cycle.
- R3: A write to $7FFF loads the character bank for PPU addresses $1000-$1FFF (ppu_addr[12] = 1). It shows in chr_addr bits above bit 11 from the next cycle.
- R4: wram_we is high in the same cycle that cpu_wr is high and cpu_addr is in $6000-$7FFC. It is low for $7FFD, $7FFE and $7FFF, low for addresses outside the window, and low while cpu_wr is low.
- R5: A stored bank equals the written byte ANDed with (bank count − 1). The bank count is ROM size / 32 KB for program and ROM size / 4 KB for character. With the defaults (64 KB each) only data bit 0 is kept for program and bits 3:0 for character.
- R6: prg_addr = {program bank, cpu_addr[14:0]} at all times.
- R7: chr_addr = {selected character bank, ppu_addr[11:0]}. chr_en is high exactly when ppu_addr < $2000.
- R8: A synchronous active-high reset clears all three banks to zero. Reset takes priority over a write in the same cycle.
- R9: A write with the strobe low, or to any address other than the three register addresses, leaves every bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one write per cycle it is high |
| ppu_addr | input | 14 | PPU address |
| prg_addr | output | 15+PRG bank bits (16) | Program ROM address |
| chr_addr | output | 12+CHR bank bits (16) | Character ROM address |
| chr_en | output | 1 | PPU address lies in pattern space |
| wram_we | output | 1 | Gated work-RAM write enable |

## Verification
wram_we and both ROM addresses are combinational from the inputs and the bank registers. The bench therefore samples them one time unit after driving the inputs on the falling edge. A bank written while the strobe is high shows up only after the next rising edge. The bench ends the write at the following falling edge and checks the composed addresses there, one cycle after the write. Reset is applied the same way, so a cleared bank is checked one edge after reset is sampled.

// File: rtl/ovl_map_pkg.sv
package ovl_map_pkg;

    localparam logic [15:0] ADDR_PRG_REG  = 16'h7FFD;
    localparam logic [15:0] ADDR_CHR0_REG = 16'h7FFE;
    localparam logic [15:0] ADDR_CHR1_REG = 16'h7FFF;
    localparam logic [2:0]  WRAM_TOP3     = 3'b011;   // $6000-$7FFF

    localparam int PRG_BANK_KB = 32;
    localparam int CHR_BANK_KB = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PRG  = 2'd1,
        SEL_CHR0 = 2'd2,
        SEL_CHR1 = 2'd3
    } ovl_sel_e;

    typedef struct packed {
        ovl_sel_e sel;
        logic     wram_we;
    } ovl_dec_t;

    function automatic int bank_bits(input int banks);
        return (banks > 1) ? $clog2(banks) : 1;
    endfunction

    function automatic logic [7:0] bank_mask(input int banks);
        return 8'(banks - 1);
    endfunction

    function automatic ovl_dec_t decode_write(input logic [15:0] addr, input logic wr);
        ovl_dec_t d;
        d.sel     = SEL_NONE;
        d.wram_we = 1'b0;
        if (wr && addr[15:13] == WRAM_TOP3) begin
            unique case (addr)
                ADDR_PRG_REG:  d.sel = SEL_PRG;
                ADDR_CHR0_REG: d.sel = SEL_CHR0;
                ADDR_CHR1_REG: d.sel = SEL_CHR1;
                default:       d.wram_we = 1'b1;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/ovl_decode.sv
module ovl_decode
    import ovl_map_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    output ovl_dec_t    dec
);
    always_comb dec = decode_write(cpu_addr, cpu_wr);
endmodule

// File: rtl/ovl_bank_regs.sv
module ovl_bank_regs
    import ovl_map_pkg::*;
#(
    parameter int         PRG_BW   = 1,
    parameter int         CHR_BW   = 4,
    parameter logic [7:0] PRG_MASK = 8'h01,
    parameter logic [7:0] CHR_MASK = 8'h0F
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ovl_sel_e               sel,
    input  logic [7:0]             data,
    output logic [PRG_BW-1:0]      prg_bank,
    output logic [1:0][CHR_BW-1:0] chr_bank
);
    logic [7:0] prg_masked;
    logic [7:0] chr_masked;

    always_comb begin
        prg_masked = data & PRG_MASK;
        chr_masked = data & CHR_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)                prg_bank <= '0;
        else if (sel == SEL_PRG) prg_bank <= prg_masked[PRG_BW-1:0];
    end

    for (genvar i = 0; i < 2; i++) begin : g_chr
        localparam ovl_sel_e MY_SEL = (i == 0) ? SEL_CHR0 : SEL_CHR1;
        always_ff @(posedge clk) begin
            if (rst)                chr_bank[i] <= '0;
            else if (sel == MY_SEL) chr_bank[i] <= chr_masked[CHR_BW-1:0];
        end
    end
endmodule

// File: rtl/ovl_addr_mux.sv
module ovl_addr_mux #(
    parameter int PRG_BW = 1,
    parameter int CHR_BW = 4
) (
    input  logic [PRG_BW-1:0]      prg_bank,
    input  logic [1:0][CHR_BW-1:0] chr_bank,
    input  logic [14:0]            cpu_low,
    input  logic [13:0]            ppu_addr,
    output logic [PRG_BW+14:0]     prg_addr,
    output logic [CHR_BW+11:0]     chr_addr,
    output logic                   chr_en
);
    always_comb begin
        prg_addr = {prg_bank, cpu_low};
        chr_addr = {chr_bank[ppu_addr[12]], ppu_addr[11:0]};
        chr_en   = (ppu_addr[13] == 1'b0);
    end
endmodule

// File: rtl/ovl_bank_mapper.sv
module ovl_bank_mapper
    import ovl_map_pkg::*;
#(
    parameter int PRG_ROM_KB = 64,
    parameter int CHR_ROM_KB = 64,
    localparam int PRG_BANKS = PRG_ROM_KB / PRG_BANK_KB,
    localparam int CHR_BANKS = CHR_ROM_KB / CHR_BANK_KB,
    localparam int PRG_BW    = bank_bits(PRG_BANKS),
    localparam int CHR_BW    = bank_bits(CHR_BANKS),
    localparam int PRG_AW    = PRG_BW + 15,
    localparam int CHR_AW    = CHR_BW + 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [13:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_en,
    output logic              wram_we
);
    ovl_dec_t                dec;
    logic [PRG_BW-1:0]       prg_bank;
    logic [1:0][CHR_BW-1:0]  chr_bank;

    ovl_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .dec      (dec)
    );

    ovl_bank_regs #(
        .PRG_BW   (PRG_BW),
        .CHR_BW   (CHR_BW),
        .PRG_MASK (bank_mask(PRG_BANKS)),
        .CHR_MASK (bank_mask(CHR_BANKS))
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (dec.sel),
        .data     (cpu_data),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );

    ovl_addr_mux #(
        .PRG_BW (PRG_BW),
        .CHR_BW (CHR_BW)
    ) u_mux (
        .prg_bank (prg_bank),
        .chr_bank (chr_bank),
        .cpu_low  (cpu_addr[14:0]),
        .ppu_addr (ppu_addr),
        .prg_addr (prg_addr),
        .chr_addr (chr_addr),
        .chr_en   (chr_en)
    );

    assign wram_we = dec.wram_we;
endmodule

// File: rtl/ovl_bank_mapper_chk.sv
module ovl_bank_mapper_chk
    import ovl_map_pkg::*;
#(
    parameter int PRG_ROM_KB = 64,
    parameter int CHR_ROM_KB = 64,
    localparam int PRG_BANKS = PRG_ROM_KB / PRG_BANK_KB,
    localparam int CHR_BANKS = CHR_ROM_KB / CHR_BANK_KB,
    localparam int PRG_BW    = bank_bits(PRG_BANKS),
    localparam int CHR_BW    = bank_bits(CHR_BANKS),
    localparam int PRG_AW    = PRG_BW + 15,
    localparam int CHR_AW    = CHR_BW + 12,
    localparam logic [7:0] PM = bank_mask(PRG_BANKS),
    localparam logic [7:0] CM = bank_mask(CHR_BANKS)
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_data,
    input logic              cpu_wr,
    input logic [13:0]       ppu_addr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              chr_en,
    input logic              wram_we
);
    logic [7:0] pm_data, cm_data;
    assign pm_data = cpu_data & PM;
    assign cm_data = cpu_data & CM;

    assert_prg_load_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == ADDR_PRG_REG) |=>
        (prg_addr[PRG_AW-1:15] == $past(pm_data[PRG_BW-1:0])));

    assert_chr0_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == ADDR_CHR0_REG) |=>
        (ppu_addr[12] || chr_addr[CHR_AW-1:12] == $past(cm_data[CHR_BW-1:0])));

    assert_chr1_load_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == ADDR_CHR1_REG) |=>
        (!ppu_addr[12] || chr_addr[CHR_AW-1:12] == $past(cm_data[CHR_BW-1:0])));

    assert_wram_gate_R4: assert property (@(posedge clk) disable iff (rst)
        wram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b011 && cpu_addr < ADDR_PRG_REG));

    assert_prg_low_R6: assert property (@(posedge clk) disable iff (rst)
        prg_addr[14:0] == cpu_addr[14:0]);

    assert_chr_low_R7: assert property (@(posedge clk) disable iff (rst)
        chr_addr[11:0] == ppu_addr[11:0] && chr_en == (ppu_addr < 14'h2000));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (prg_addr[PRG_AW-1:15] == '0));

    assert_prg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr == ADDR_PRG_REG) |=> $stable(prg_addr[PRG_AW-1:15]));
endmodule

bind ovl_bank_mapper ovl_bank_mapper_chk #(
    .PRG_ROM_KB (PRG_ROM_KB),
    .CHR_ROM_KB (CHR_ROM_KB)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .ppu_addr (ppu_addr),
    .prg_addr (prg_addr),
    .chr_addr (chr_addr),
    .chr_en   (chr_en),
    .wram_we  (wram_we)
);

// File: tb/ovl_bank_mapper_tb.sv
module ovl_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [15:0] prg_addr;
    logic [15:0] chr_addr;
    logic        chr_en;
    logic        wram_we;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    ovl_bank_mapper u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .chr_en(chr_en), .wram_we(wram_we)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        we;
        logic        prg;
        logic [3:0]  c0;
        logic [3:0]  c1;
    } vec_t;

    // cumulative expected banks after each write; defaults mask prg to bit 0, chr to 3:0
    localparam vec_t VEC [10] = '{
        '{16'h7FFD, 8'h03, 1'b0, 1'b1, 4'h0, 4'h0},
        '{16'h7FFE, 8'h1A, 1'b0, 1'b1, 4'hA, 4'h0},
        '{16'h7FFF, 8'hF5, 1'b0, 1'b1, 4'hA, 4'h5},
        '{16'h6000, 8'hFF, 1'b1, 1'b1, 4'hA, 4'h5},
        '{16'h7FFC, 8'h00, 1'b1, 1'b1, 4'hA, 4'h5},
        '{16'hFFFD, 8'h00, 1'b0, 1'b1, 4'hA, 4'h5},
        '{16'h5FFD, 8'h00, 1'b0, 1'b1, 4'hA, 4'h5},
        '{16'h7FFD, 8'h02, 1'b0, 1'b0, 4'hA, 4'h5},
        '{16'h7FFE, 8'h0F, 1'b0, 1'b0, 4'hF, 4'h5},
        '{16'h7FFF, 8'h00, 1'b0, 1'b0, 4'hF, 4'h0}
    };

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // check composed addresses for expected banks (one cycle after a write)
    task automatic check_banks(input string req, input logic p, input logic [3:0] c0,
                               input logic [3:0] c1);
        cpu_wr = 1'b0;
        cpu_addr = 16'hC123;
        ppu_addr = 14'h0456;
        #1;
        check({req, " R6 prg_addr"}, int'(prg_addr), int'({p, 15'h4123}));
        check({req, " R2 chr lo"}, int'(chr_addr), int'({c0, 12'h456}));
        ppu_addr = 14'h1ABC;
        #1;
        check({req, " R3 chr hi"}, int'(chr_addr), int'({c1, 12'hABC}));
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = strobe;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_banks("R8 reset state", 1'b0, 4'h0, 4'h0);
        check("R4 idle we", int'(wram_we), 0);

        foreach (VEC[i]) begin
            do_write(VEC[i].addr, VEC[i].data, 1'b1);
            check($sformatf("R4 we vec%0d", i), int'(wram_we), int'(VEC[i].we));
            @(negedge clk);
            check_banks($sformatf("R1 R5 R9 vec%0d", i), VEC[i].prg, VEC[i].c0, VEC[i].c1);
        end

        // R9: strobe low at register address
        do_write(16'h7FFD, 8'h01, 1'b0);
        check("R4 strobe low we", int'(wram_we), 0);
        @(negedge clk);
        check_banks("R9 strobe low", 1'b0, 4'hF, 4'h0);

        // R4: strobe low inside window, and top-of-window neighbour
        do_write(16'h6ABC, 8'h00, 1'b0);
        check("R4 window no strobe", int'(wram_we), 0);
        do_write(16'h8000, 8'h00, 1'b1);
        check("R4 rom space", int'(wram_we), 0);

        // R7: chr_en boundary
        @(negedge clk);
        cpu_wr = 1'b0;
        ppu_addr = 14'h1FFF; #1;
        check("R7 chr_en 1FFF", int'(chr_en), 1);
        ppu_addr = 14'h2000; #1;
        check("R7 chr_en 2000", int'(chr_en), 0);

        // R8: reset beats same-cycle write
        do_write(16'h7FFD, 8'h01, 1'b1);
        @(negedge clk);
        check_banks("R1 prg set", 1'b1, 4'hF, 4'h0);
        do_write(16'h7FFE, 8'h07, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_banks("R8 reset over write", 1'b0, 4'h0, 4'h0);

        done = 1;
        finish_run();
    end
endmodule